// File: doc/BRIEF.md
# Memory Test Address Sequencer

This block produces the address stream for a DRAM self-test pass. Each address is split into a row field, a bank field and a column field. A rank select travels alongside the address. A caller sets up a pass in one cycle by pulsing `start` with these inputs:
- a range type;
- a pair of bound addresses;
- a loop-nesting order;
- a direction;
- a rank select.

The block then shows the first address of the pass. Each cycle in which `req` is high while the pass runs moves it to the next address.

The bounds are packed as `{row, bank, col}`, with the column in the least significant bits. Each bound is read field by field. The pass covers the box whose corners are the lower and upper bound. Every field runs between its own two bound values. The range type chooses between this box, the whole device, and a single address. The final address of a pass is marked by `last_o`. Accepting a request on that address ends the pass. The outputs then hold until the next `start`.

Command issue, data patterns and read comparison belong to other blocks. The geometry is fixed by the parameters `ROW_W`, `BANK_W` and `COL_W`.

Top module: `mt_addr_seq`

## Requirements
- R1: After reset, `busy_o` and `last_o` are 0, and `row_o`, `bank_o`, `col_o` and `rank_o` are all 0.
- R2: A `start` sampled at a clock edge makes `busy_o` 1 in the next cycle. The outputs then show the first address of the pass: the lower bound of every field when ascending, the upper bound of every field when descending.
- R3: With `range_mode` = 2'b11 every field runs from 0 to its maximum, and `lo_addr`/`hi_addr` have no effect on the sequence.
- R4: With `range_mode` = 2'b10 each field runs from its value in `lo_addr` to its value in `hi_addr`, inclusive. The bounds are packed `{row, bank, col}` with the column in the low bits. The pass visits every address of the box exactly once. It is the same pass as mode 2'b11 when `lo_addr` is 0 and `hi_addr` is all ones.
- R5: `order` = 2'b00 nests the loops with the column innermost, then the row, with the bank outermost.
- R6: `order` = 2'b01 nests the loops with the row innermost, then the column, with the bank outermost.
- R7: `order` = 2'b11 nests the loops with the column innermost, then the bank, with the row outermost.
- R8: With `order` = 2'b10 the bank is outermost. The row/column plane is swept column-fast on the first, third, fifth… bank iteration of the pass. It is swept row-fast on the second, fourth… bank iteration.
- R9: With `descend` = 1 every field counts down. A field that steps below its lower bound reloads its upper bound, and the next enclosing loop takes one step.
- R10: `last_o` is 1 exactly while the final address of the pass is shown. A `req` accepted on that address drops `busy_o` in the next cycle, and the fields keep the final address. `req` while `busy_o` is 0 changes no output.
- R11: `rank_o` shows the value of `rank_sel` taken at `start`. Changes of `rank_sel`, `lo_addr`, `hi_addr`, `order`, `descend` or `range_mode` during a pass do not change the pass.
- R12: With `range_mode[1]` = 0 the pass is the single address `lo_addr`, and `last_o` is 1 at once.
- R13: With `busy_o` = 1 and `req` = 0 the address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latches the configuration and begins a pass |
| range_mode | input | 2 | 11 full device, 10 bounded box, 0x single address |
| lo_addr | input | ROW_W+BANK_W+COL_W | Lower bound, packed {row, bank, col} |
| hi_addr | input | ROW_W+BANK_W+COL_W | Upper bound, packed {row, bank, col} |
| order | input | 2 | Loop nesting: 00 col/row/bank, 01 row/col/bank, 10 alternating plane, 11 col/bank/row |
| descend | input | 1 | 1 counts every field down |
| rank_sel | input | 2 | Rank select captured at start |
| req | input | 1 | Request for the next address |
| row_o | output | ROW_W | Current row |
| bank_o | output | BANK_W | Current bank |
| col_o | output | COL_W | Current column |
| rank_o | output | 2 | Captured rank select |
| busy_o | output | 1 | A pass is running and the address is valid |
| last_o | output | 1 | Current address is the last of the pass |

## Verification
The hardest case is the alternating-plane order. Here the switch between column-fast and row-fast depends on how many times the plane has completed since `start`, and not on any field value. It shows up only in a pass that completes at least two planes. Its interaction with a non-zero lower bank bound and with counting down is easier still to miss. The bench sweeps every order with both directions over the full device and over two offset boxes, one of which collapses two fields to a single value. Each run is compared step by step against nested loops computed in the bench. Midway through each pass the bench changes every configuration input to garbage, to show that only the values captured at `start` matter.

// File: rtl/mt_addr_seq.sv
module mt_addr_seq #(
  parameter int ROW_W  = 3,
  parameter int BANK_W = 2,
  parameter int COL_W  = 2,
  localparam int AW    = ROW_W + BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        range_mode,
  input  logic [AW-1:0]     lo_addr,
  input  logic [AW-1:0]     hi_addr,
  input  logic [1:0]        order,
  input  logic              descend,
  input  logic [1:0]        rank_sel,
  input  logic              req,
  output logic [ROW_W-1:0]  row_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic [1:0]        rank_o,
  output logic              busy_o,
  output logic              last_o
);
  localparam int CB = COL_W + BANK_W;

  logic [ROW_W-1:0]  row_q, r_lo, r_hi, r_nx, in_r_lo, in_r_hi;
  logic [BANK_W-1:0] bank_q, b_lo, b_hi, b_nx, in_b_lo, in_b_hi;
  logic [COL_W-1:0]  col_q, c_lo, c_hi, c_nx, in_c_lo, in_c_hi;
  logic [1:0]        ord_q, rank_q, lv_r, lv_b, lv_c;
  logic              dsc_q, ph_q, busy_q;
  logic              full, single, r_end, b_end, c_end, in_end, mid_end;
  logic              adv_r, adv_b, adv_c, last;

  assign full   = range_mode == 2'b11;
  assign single = !range_mode[1];

  assign in_r_lo = full ? '0 : lo_addr[AW-1:CB];
  assign in_b_lo = full ? '0 : lo_addr[CB-1:COL_W];
  assign in_c_lo = full ? '0 : lo_addr[COL_W-1:0];
  assign in_r_hi = full ? '1 : single ? lo_addr[AW-1:CB]    : hi_addr[AW-1:CB];
  assign in_b_hi = full ? '1 : single ? lo_addr[CB-1:COL_W] : hi_addr[CB-1:COL_W];
  assign in_c_hi = full ? '1 : single ? lo_addr[COL_W-1:0]  : hi_addr[COL_W-1:0];

  assign r_end = dsc_q ? (row_q == r_lo)  : (row_q == r_hi);
  assign b_end = dsc_q ? (bank_q == b_lo) : (bank_q == b_hi);
  assign c_end = dsc_q ? (col_q == c_lo)  : (col_q == c_hi);

  assign r_nx = r_end ? (dsc_q ? r_hi : r_lo) : (dsc_q ? row_q - 1'b1  : row_q + 1'b1);
  assign b_nx = b_end ? (dsc_q ? b_hi : b_lo) : (dsc_q ? bank_q - 1'b1 : bank_q + 1'b1);
  assign c_nx = c_end ? (dsc_q ? c_hi : c_lo) : (dsc_q ? col_q - 1'b1  : col_q + 1'b1);

  always_comb begin
    case (ord_q)
      2'b00:   begin lv_c = 2'd0; lv_r = 2'd1; lv_b = 2'd2; end
      2'b01:   begin lv_r = 2'd0; lv_c = 2'd1; lv_b = 2'd2; end
      2'b11:   begin lv_c = 2'd0; lv_b = 2'd1; lv_r = 2'd2; end
      default: begin
        lv_b = 2'd2;
        lv_c = ph_q ? 2'd1 : 2'd0;
        lv_r = ph_q ? 2'd0 : 2'd1;
      end
    endcase
  end

  assign in_end  = (lv_c == 2'd0 && c_end) || (lv_r == 2'd0 && r_end) || (lv_b == 2'd0 && b_end);
  assign mid_end = (lv_c == 2'd1 && c_end) || (lv_r == 2'd1 && r_end) || (lv_b == 2'd1 && b_end);

  assign adv_c = (lv_c == 2'd0) || (lv_c == 2'd1 && in_end) || (lv_c == 2'd2 && in_end && mid_end);
  assign adv_r = (lv_r == 2'd0) || (lv_r == 2'd1 && in_end) || (lv_r == 2'd2 && in_end && mid_end);
  assign adv_b = (lv_b == 2'd0) || (lv_b == 2'd1 && in_end) || (lv_b == 2'd2 && in_end && mid_end);

  assign last = busy_q && r_end && b_end && c_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0; bank_q <= '0; col_q <= '0;
      r_lo <= '0; r_hi <= '0; b_lo <= '0; b_hi <= '0; c_lo <= '0; c_hi <= '0;
      ord_q <= '0; rank_q <= '0; dsc_q <= 1'b0; ph_q <= 1'b0; busy_q <= 1'b0;
    end else if (start) begin
      r_lo <= in_r_lo; r_hi <= in_r_hi;
      b_lo <= in_b_lo; b_hi <= in_b_hi;
      c_lo <= in_c_lo; c_hi <= in_c_hi;
      row_q  <= descend ? in_r_hi : in_r_lo;
      bank_q <= descend ? in_b_hi : in_b_lo;
      col_q  <= descend ? in_c_hi : in_c_lo;
      ord_q  <= order;
      dsc_q  <= descend;
      rank_q <= rank_sel;
      ph_q   <= 1'b0;
      busy_q <= 1'b1;
    end else if (busy_q && req) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        if (adv_r) row_q  <= r_nx;
        if (adv_b) bank_q <= b_nx;
        if (adv_c) col_q  <= c_nx;
        if (in_end && mid_end) ph_q <= !ph_q;
      end
    end
  end

  assign row_o  = row_q;
  assign bank_o = bank_q;
  assign col_o  = col_q;
  assign rank_o = rank_q;
  assign busy_o = busy_q;
  assign last_o = last;
endmodule

// File: rtl/mt_addr_seq_chk.sv
module mt_addr_seq_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          req,
  input logic [AW-1:0] addr,
  input logic [1:0]    rank_o,
  input logic          busy_o,
  input logic          last_o
);
  a_r10_last_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> busy_o);

  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_o);

  a_r10_end_of_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && last_o && req && !start) |=> (!busy_o && $stable(addr)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start) |=> (!busy_o && $stable(addr) && $stable(rank_o)));

  a_r11_rank_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start) |=> $stable(rank_o));

  a_r13_hold_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !req && !start) |=> (busy_o && $stable(addr)));

  a_r4_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req && !last_o && !start) |=> (busy_o && !$stable(addr)));
endmodule

bind mt_addr_seq mt_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req(req),
  .addr({row_o, bank_o, col_o}), .rank_o(rank_o),
  .busy_o(busy_o), .last_o(last_o)
);

// File: tb/tb_mt_addr_seq.sv
module tb_mt_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 3, BW = 2, CW = 2;
  localparam int AW = RW + BW + CW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, descend = 1'b0, req = 1'b0;
  logic [1:0] range_mode = '0, order = '0, rank_sel = '0;
  logic [AW-1:0] lo_addr = '0, hi_addr = '0;
  logic [RW-1:0] row_o;
  logic [BW-1:0] bank_o;
  logic [CW-1:0] col_o;
  logic [1:0] rank_o;
  logic busy_o, last_o;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int er[512], eb[512], ec[512];
  int n;

  always #(CLK_PERIOD/2) clk = ~clk;

  mt_addr_seq #(.ROW_W(RW), .BANK_W(BW), .COL_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .range_mode(range_mode),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .order(order), .descend(descend),
    .rank_sel(rank_sel), .req(req), .row_o(row_o), .bank_o(bank_o),
    .col_o(col_o), .rank_o(rank_o), .busy_o(busy_o), .last_o(last_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fv(int lo, int hi, int k, bit d);
    return d ? hi - k : lo + k;
  endfunction

  function automatic int pack(int r, int b, int c);
    return (r << (BW + CW)) | (b << CW) | c;
  endfunction

  // Expected pass from nested loops (R3-R9, R12)
  task automatic build(input int mode, input int ord, input bit d,
                       input int lr, input int hr, input int lb, input int hb,
                       input int lc, input int hc);
    int nr, nb, nc;
    if (mode == 3) begin
      lr = 0; hr = (1 << RW) - 1; lb = 0; hb = (1 << BW) - 1; lc = 0; hc = (1 << CW) - 1;
    end else if (mode < 2) begin
      hr = lr; hb = lb; hc = lc;
    end
    nr = hr - lr + 1; nb = hb - lb + 1; nc = hc - lc + 1;
    n = 0;
    if (ord == 3) begin
      for (int r = 0; r < nr; r++) for (int b = 0; b < nb; b++) for (int c = 0; c < nc; c++) begin
        er[n] = fv(lr, hr, r, d); eb[n] = fv(lb, hb, b, d); ec[n] = fv(lc, hc, c, d); n++;
      end
    end else begin
      for (int b = 0; b < nb; b++) begin
        if (ord == 0 || (ord == 2 && b % 2 == 0)) begin
          for (int r = 0; r < nr; r++) for (int c = 0; c < nc; c++) begin
            er[n] = fv(lr, hr, r, d); eb[n] = fv(lb, hb, b, d); ec[n] = fv(lc, hc, c, d); n++;
          end
        end else begin
          for (int c = 0; c < nc; c++) for (int r = 0; r < nr; r++) begin
            er[n] = fv(lr, hr, r, d); eb[n] = fv(lb, hb, b, d); ec[n] = fv(lc, hc, c, d); n++;
          end
        end
      end
    end
  endtask

  task automatic run(input int mode, input int ord, input bit d,
                     input int lr, input int hr, input int lb, input int hb,
                     input int lc, input int hc, input int rk);
    int addr_now;
    build(mode, ord, d, lr, hr, lb, hb, lc, hc);
    @(negedge clk);
    range_mode = 2'(mode); order = 2'(ord); descend = d; rank_sel = 2'(rk);
    lo_addr = AW'(pack(lr, lb, lc)); hi_addr = AW'(pack(hr, hb, hc));
    if (mode == 3) begin lo_addr = AW'(pack(5, 2, 1)); hi_addr = AW'(pack(2, 1, 2)); end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy_o === 1'b1, "R2 busy after start", busy_o, 1);
    chk(row_o == er[0] && bank_o == eb[0] && col_o == ec[0], "R2 first address",
        pack(row_o, bank_o, col_o), pack(er[0], eb[0], ec[0]));
    req = 1'b0;
    @(negedge clk);
    chk(busy_o && row_o == er[0] && bank_o == eb[0] && col_o == ec[0], "R13 hold without req",
        pack(row_o, bank_o, col_o), pack(er[0], eb[0], ec[0]));
    req = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (i == 1) begin
        rank_sel = ~rank_sel; lo_addr = ~lo_addr; hi_addr = ~hi_addr;
        order = ~order; descend = ~descend; range_mode = ~range_mode;
      end
      addr_now = pack(row_o, bank_o, col_o);
      if (mode == 3)
        chk(addr_now == pack(er[i], eb[i], ec[i]), "R3 full sweep", addr_now, pack(er[i], eb[i], ec[i]));
      else if (mode < 2)
        chk(addr_now == pack(er[i], eb[i], ec[i]), "R12 single address", addr_now, pack(er[i], eb[i], ec[i]));
      else if (ord == 0)
        chk(addr_now == pack(er[i], eb[i], ec[i]), "R5 col/row/bank order", addr_now, pack(er[i], eb[i], ec[i]));
      else if (ord == 1)
        chk(addr_now == pack(er[i], eb[i], ec[i]), "R6 row/col/bank order", addr_now, pack(er[i], eb[i], ec[i]));
      else if (ord == 2)
        chk(addr_now == pack(er[i], eb[i], ec[i]), "R8 alternating plane", addr_now, pack(er[i], eb[i], ec[i]));
      else
        chk(addr_now == pack(er[i], eb[i], ec[i]), "R7 col/bank/row order", addr_now, pack(er[i], eb[i], ec[i]));
      if (d)
        chk(addr_now == pack(er[i], eb[i], ec[i]), "R9 descending", addr_now, pack(er[i], eb[i], ec[i]));
      chk(busy_o === 1'b1, "R4 busy through box", busy_o, 1);
      chk(last_o === (i == n - 1), "R10 last flag", last_o, (i == n - 1));
      chk(rank_o == 2'(rk), "R11 rank captured", rank_o, rk);
      @(negedge clk);
    end
    chk(busy_o === 1'b0, "R10 pass ends", busy_o, 0);
    chk(pack(row_o, bank_o, col_o) == pack(er[n-1], eb[n-1], ec[n-1]), "R10 final address held",
        pack(row_o, bank_o, col_o), pack(er[n-1], eb[n-1], ec[n-1]));
    @(negedge clk);
    chk(!busy_o && !last_o && pack(row_o, bank_o, col_o) == pack(er[n-1], eb[n-1], ec[n-1]),
        "R10 idle req ignored", pack(row_o, bank_o, col_o), pack(er[n-1], eb[n-1], ec[n-1]));
    req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !last_o, "R1 reset flags", {busy_o, last_o}, 0);
    chk(pack(row_o, bank_o, col_o) == 0 && rank_o == 0, "R1 reset address",
        pack(row_o, bank_o, col_o), 0);
    rst_n = 1'b1;
    for (int o = 0; o < 4; o++) begin
      for (int d = 0; d < 2; d++) begin
        run(3, o, d[0], 0, 0, 0, 0, 0, 0, o);
        run(2, o, d[0], 1, 5, 1, 3, 1, 2, 3 - o);
        run(2, o, d[0], 2, 2, 0, 3, 3, 3, 1);
        run(2, o, d[0], 0, 7, 0, 3, 0, 3, 2);
      end
    end
    run(0, 1, 1'b0, 6, 0, 2, 0, 1, 0, 2);
    run(1, 2, 1'b1, 3, 0, 1, 0, 3, 0, 1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule